// File: doc/BRIEF.md
# SPI Channel Transfer Controller

This block is one channel of a multichannel SPI master. It holds the channel's configuration, control, status and data registers behind a small word-wide register port. It starts a word transfer through its own serial shift engine whenever the channel is enabled and the mode, status flags and module single-channel setting allow one. Software or a DMA engine feeds it by writing the transmit register and draining the receive register.

The channel supports three modes: transmit-receive, receive-only and transmit-only. It also has a turbo option that lets a new word go out while the previous received word is still unread, and a forced-transfer option that shifts even while the module is in single-channel mode. Per-direction DMA request levels and transmit-empty / receive-full event levels go to the neighbouring DMA and interrupt logic. The shift engine drives SCLK, MOSI and samples MISO in SPI mode 0 (clock idle low, data sampled on the rising edge, changed on the falling edge), most significant bit first, for a programmable word length.

Register offsets on `reg_addr`: 0 configuration, 1 status, 2 control, 3 transmit data, 4 receive data. Reads return data combinationally in the cycle `reg_rd` is high. Side effects take place at the clock edge.

Top module: `spi_chan_ctrl`

## Requirements
- R1: After reset the configuration reads 0x060000, the status reads 0x2, the control reads 0, `sclk` is low and neither DMA request is active.
- R2: The configuration register keeps bits [22:0] of a write and reads zero above them. Bits [13:12] give the mode: 0 transmit-receive, 1 receive-only, 2 transmit-only, 3 behaves as transmit-receive. Bit 14 enables transmit DMA, bit 15 enables receive DMA, bit 19 is turbo and bit 20 is force.
- R3: A shifted transfer returns in the receive register exactly the bits sampled on MISO, right-aligned to the word length. The word length is configuration bits [11:7] plus 1.
- R4: Status bit 0 is receive full, bit 1 is transmit empty and bit 2 is end of transfer. A completed transfer clears the transmit register and sets end of transfer and transmit empty. It also sets receive full unless the mode is transmit-only.
- R5: No transfer starts while any of these holds: enable (control bit 0) is clear; receive full is set with the mode not transmit-only and turbo clear; transmit empty is set with the mode not receive-only.
- R6: When the module single-channel input is high and force is clear, an allowed transfer completes in one cycle without toggling `sclk` and leaves the receive register unchanged. With force set it shifts normally.
- R7: Writing the transmit register stores the word and clears transmit empty. Reading the receive register returns the word and clears receive full. Either may let a transfer start.
- R8: `tx_dma_req` is high exactly when enable, configuration bit 14 and transmit empty are set and the mode is not receive-only. `rx_dma_req` is high exactly when enable, bit 15 and receive full are set and the mode is not transmit-only.
- R9: `evt_tx_empty` is high when transmit empty is set and the mode is not receive-only. `evt_rx_full` is high when receive full is set, the mode is not transmit-only and turbo is clear.
- R10: A control write stores only bit 0. Setting enable lets a transfer start with no further access, which in receive-only mode starts one at once.
- R11: The shift engine produces exactly word-length rising `sclk` edges per transfer, most significant bit first on MOSI, and `xfer_busy` stays high until the last sampled bit is captured.
- R12: Writes to the status and receive data offsets change nothing.
- R13: End of transfer clears when a shifted transfer starts. A length field below 3 shifts 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational on `reg_addr` |
| single_chan | input | 1 | Module single-channel mode |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| xfer_busy | output | 1 | Shift engine active |
| tx_dma_req | output | 1 | Transmit DMA request level |
| rx_dma_req | output | 1 | Receive DMA request level |
| evt_tx_empty | output | 1 | Transmit-empty event level |
| evt_rx_full | output | 1 | Receive-full event level |

## Verification
The assertions assume a transmit write never lands in the same cycle as the engine's completion, and a receive read never lands in the same cycle as a completion. They also assume the register port never writes and reads in one cycle. The bench keeps within these assumptions: it issues one access at a time and waits for `xfer_busy` to fall before touching the data registers again. The only exception is the deliberate receive-full and disabled-channel cases, where no transfer can be running. MISO is looped back inverted from MOSI, so every received word has a known expected value derived from the transmitted word and the word length.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

    localparam int CONF_W = 23;
    localparam logic [CONF_W-1:0] CONF_RST = 23'h060000;

    // register offsets
    localparam logic [2:0] OFS_CONF = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CTRL = 3'd2;
    localparam logic [2:0] OFS_TXD  = 3'd3;
    localparam logic [2:0] OFS_RXD  = 3'd4;

    // configuration field positions
    localparam int CF_LEN_LO  = 7;
    localparam int CF_LEN_HI  = 11;
    localparam int CF_MODE_LO = 12;
    localparam int CF_MODE_HI = 13;
    localparam int CF_DMA_TX  = 14;
    localparam int CF_DMA_RX  = 15;
    localparam int CF_TURBO   = 19;
    localparam int CF_FORCE   = 20;

    // smallest legal length field
    localparam logic [4:0] LEN_FIELD_MIN = 5'd3;

    typedef enum logic [1:0] {
        MODE_TXRX   = 2'd0,
        MODE_RXONLY = 2'd1,
        MODE_TXONLY = 2'd2,
        MODE_BAD    = 2'd3
    } xfer_mode_e;

endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W   = 32,
    parameter int HALF_DIV = 2,
    localparam int BW      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BW-1:0]     wl,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic [CW-1:0]     div;
        logic [BW-1:0]     bits;
        logic [DATA_W-1:0] tx_sr;
        logic [DATA_W-1:0] rx_sr;
    } eng_t;

    eng_t eng_d, eng_q;
    logic tick;
    logic [BW-1:0] align;

    always_comb begin
        eng_d = eng_q;
        tick  = (eng_q.div == CW'(HALF_DIV - 1));
        done  = eng_q.busy && tick && eng_q.sclk && (eng_q.bits == BW'(1));
        align = BW'(DATA_W) - wl;
        if (start) begin
            eng_d.busy  = 1'b1;
            eng_d.sclk  = 1'b0;
            eng_d.div   = '0;
            eng_d.bits  = wl;
            eng_d.tx_sr = tx_word << align;
            eng_d.rx_sr = '0;
        end else if (eng_q.busy) begin
            if (tick) begin
                eng_d.div = '0;
                if (!eng_q.sclk) begin
                    eng_d.sclk  = 1'b1;
                    eng_d.rx_sr = {eng_q.rx_sr[DATA_W-2:0], miso};
                end else begin
                    eng_d.sclk = 1'b0;
                    if (eng_q.bits == BW'(1)) begin
                        eng_d.busy = 1'b0;
                    end else begin
                        eng_d.bits  = eng_q.bits - BW'(1);
                        eng_d.tx_sr = {eng_q.tx_sr[DATA_W-2:0], 1'b0};
                    end
                end
            end else begin
                eng_d.div = eng_q.div + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign sclk    = eng_q.sclk;
    assign mosi    = eng_q.tx_sr[DATA_W-1];
    assign busy    = eng_q.busy;
    assign rx_word = eng_q.rx_sr;

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !eng_q.busy); // R11
    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_q.busy |-> !eng_q.sclk); // R11
    AST_DONE_RELEASES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !eng_q.busy); // R11
    AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.busy |-> (eng_q.bits != '0) && (eng_q.bits <= BW'(DATA_W))); // R11

endmodule

// File: rtl/spi_chan_req.sv
module spi_chan_req
    import spi_chan_pkg::*;
(
    input  logic       en,
    input  logic [1:0] mode,
    input  logic       dma_tx_en,
    input  logic       dma_rx_en,
    input  logic       turbo,
    input  logic       tx_empty,
    input  logic       rx_full,
    output logic       tx_dma_req,
    output logic       rx_dma_req,
    output logic       evt_tx_empty,
    output logic       evt_rx_full,
    output logic       blocked
);
    logic tx_side, rx_side, rx_hold, tx_hold;

    always_comb begin
        tx_side      = (xfer_mode_e'(mode) != MODE_RXONLY);
        rx_side      = (xfer_mode_e'(mode) != MODE_TXONLY);
        rx_hold      = rx_full && rx_side && !turbo;
        tx_hold      = tx_empty && tx_side;
        blocked      = !en || rx_hold || tx_hold;
        tx_dma_req   = en && dma_tx_en && tx_empty && tx_side;
        rx_dma_req   = en && dma_rx_en && rx_full && rx_side;
        evt_tx_empty = tx_hold;
        evt_rx_full  = rx_hold;
    end

endmodule

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
    import spi_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BW    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              single_chan,
    input  logic              blocked,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rx,
    output logic              eng_start,
    output logic [BW-1:0]     eng_wl,
    output logic [DATA_W-1:0] eng_tx,
    output logic              en,
    output logic [1:0]        mode,
    output logic              dma_tx_en,
    output logic              dma_rx_en,
    output logic              turbo,
    output logic              tx_empty,
    output logic              rx_full
);
    typedef struct packed {
        logic [CONF_W-1:0] conf;
        logic              en;
        logic [DATA_W-1:0] txd;
        logic [DATA_W-1:0] rxd;
        logic              tx_empty;
        logic              rx_full;
        logic              eot;
    } regs_t;

    regs_t r_d, r_q;
    logic go, shift_path, quick, finish, wr_txd, rd_rxd;
    logic [4:0] len_field;

    always_comb begin
        r_d        = r_q;
        len_field  = r_q.conf[CF_LEN_HI:CF_LEN_LO];
        eng_wl     = (len_field < LEN_FIELD_MIN) ? BW'(4) : BW'(len_field) + BW'(1);
        go         = r_q.en && !blocked && !eng_busy;
        shift_path = !single_chan || r_q.conf[CF_FORCE];
        eng_start  = go && shift_path;
        quick      = go && !shift_path;
        finish     = eng_done || quick;
        wr_txd     = reg_wr && (reg_addr == OFS_TXD);
        rd_rxd     = reg_rd && (reg_addr == OFS_RXD);

        if (eng_start) r_d.eot = 1'b0;
        if (eng_done)  r_d.rxd = eng_rx;
        if (finish) begin
            r_d.txd      = '0;
            r_d.eot      = 1'b1;
            r_d.tx_empty = 1'b1;
            if (xfer_mode_e'(r_q.conf[CF_MODE_HI:CF_MODE_LO]) != MODE_TXONLY)
                r_d.rx_full = 1'b1;
        end

        if (reg_wr) begin
            unique case (reg_addr)
                OFS_CONF: r_d.conf = reg_wdata[CONF_W-1:0];
                OFS_CTRL: r_d.en   = reg_wdata[0];
                OFS_TXD: begin
                    r_d.txd      = reg_wdata;
                    r_d.tx_empty = 1'b0;
                end
                default: ; // status and receive data are read-only
            endcase
        end
        if (rd_rxd) r_d.rx_full = 1'b0;

        unique case (reg_addr)
            OFS_CONF: reg_rdata = DATA_W'(r_q.conf);
            OFS_STAT: reg_rdata = DATA_W'({r_q.eot, r_q.tx_empty, r_q.rx_full});
            OFS_CTRL: reg_rdata = DATA_W'(r_q.en);
            OFS_TXD:  reg_rdata = r_q.txd;
            OFS_RXD:  reg_rdata = r_q.rxd;
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.conf     <= CONF_RST;
            r_q.tx_empty <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign eng_tx    = r_q.txd;
    assign en        = r_q.en;
    assign mode      = r_q.conf[CF_MODE_HI:CF_MODE_LO];
    assign dma_tx_en = r_q.conf[CF_DMA_TX];
    assign dma_rx_en = r_q.conf[CF_DMA_RX];
    assign turbo     = r_q.conf[CF_TURBO];
    assign tx_empty  = r_q.tx_empty;
    assign rx_full   = r_q.rx_full;

    AST_DONE_SETS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && !wr_txd |=> r_q.tx_empty && r_q.eot && (r_q.txd == '0)); // R4
    AST_DONE_SETS_RXF: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && !rd_rxd && (mode != MODE_TXONLY) |=> r_q.rx_full); // R4
    AST_TXWRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_txd |=> !r_q.tx_empty); // R7
    AST_START_CLEARS_EOT: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !r_q.eot); // R13

endmodule

// File: rtl/spi_chan_ctrl.sv
module spi_chan_ctrl #(
    parameter int DATA_W    = 32,
    parameter int SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              single_chan,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              xfer_busy,
    output logic              tx_dma_req,
    output logic              rx_dma_req,
    output logic              evt_tx_empty,
    output logic              evt_rx_full
);
    localparam int BW = $clog2(DATA_W + 1);

    logic              blocked, eng_start, eng_done;
    logic [BW-1:0]     eng_wl;
    logic [DATA_W-1:0] eng_tx, eng_rx;
    logic              en, dma_tx_en, dma_rx_en, turbo, tx_empty, rx_full;
    logic [1:0]        mode;

    spi_chan_regs #(.DATA_W(DATA_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .single_chan(single_chan), .blocked(blocked),
        .eng_busy(xfer_busy), .eng_done(eng_done), .eng_rx(eng_rx),
        .eng_start(eng_start), .eng_wl(eng_wl), .eng_tx(eng_tx),
        .en(en), .mode(mode), .dma_tx_en(dma_tx_en), .dma_rx_en(dma_rx_en),
        .turbo(turbo), .tx_empty(tx_empty), .rx_full(rx_full)
    );

    spi_chan_req i_req (
        .en(en), .mode(mode), .dma_tx_en(dma_tx_en), .dma_rx_en(dma_rx_en),
        .turbo(turbo), .tx_empty(tx_empty), .rx_full(rx_full),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .evt_tx_empty(evt_tx_empty), .evt_rx_full(evt_rx_full),
        .blocked(blocked)
    );

    spi_shift_engine #(.DATA_W(DATA_W), .HALF_DIV(SCLK_HALF)) i_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .wl(eng_wl),
        .tx_word(eng_tx), .miso(miso), .sclk(sclk), .mosi(mosi),
        .busy(xfer_busy), .done(eng_done), .rx_word(eng_rx)
    );

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |-> $past(en)); // R5

endmodule

// File: tb/test_spi_chan_ctrl.sv
module test_spi_chan_ctrl;
    localparam logic [2:0] A_CONF = 3'd0, A_STAT = 3'd1, A_CTRL = 3'd2,
                           A_TXD = 3'd3, A_RXD = 3'd4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0, single_chan = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic sclk, mosi, miso, xfer_busy, tx_dma_req, rx_dma_req, evt_tx_empty, evt_rx_full;

    int checks = 0, fails = 0, sclk_edges = 0, mark = 0;
    logic first_mosi = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;
    assign miso = ~mosi;

    spi_chan_ctrl i_spi_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .single_chan(single_chan), .sclk(sclk), .mosi(mosi), .miso(miso),
        .xfer_busy(xfer_busy), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .evt_tx_empty(evt_tx_empty), .evt_rx_full(evt_rx_full)
    );

    always @(posedge sclk) begin
        if (sclk_edges == mark) first_mosi = mosi;
        sclk_edges = sclk_edges + 1;
    end

    function automatic logic [31:0] exp_rx(logic [31:0] tx, int wl);
        logic [31:0] m = (wl >= 32) ? 32'hFFFF_FFFF : ((32'd1 << wl) - 32'd1);
        return ~tx & m;
    endfunction

    function automatic logic [31:0] conf_word(int mode, int lenf, bit dtx, bit drx,
                                              bit turbo, bit force_x);
        return (32'(lenf) << 7) | (32'(mode) << 12) | (32'(dtx) << 14) |
               (32'(drx) << 15) | (32'(turbo) << 19) | (32'(force_x) << 20);
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        repeat (3) @(negedge clk);
        while (xfer_busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, prev;
        int e0;
        void'($urandom(32'd7321));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CONF, v); chk(v, 32'h060000, "R1 conf reset");
        rd(A_STAT, v); chk(v, 32'h2, "R1 status reset");
        rd(A_CTRL, v); chk(v, 32'h0, "R1 control reset");
        chk({31'd0, sclk}, 0, "R1 sclk idle");
        chk({30'd0, tx_dma_req, rx_dma_req}, 0, "R1 dma idle");

        // R2 config width
        wr(A_CONF, 32'hFFFF_FFFF);
        rd(A_CONF, v); chk(v, 32'h7F_FFFF, "R2 conf keeps 23 bits");
        // R12 read-only offsets
        wr(A_STAT, 32'h0); rd(A_STAT, v); chk(v, 32'h2, "R12 status write ignored");
        wr(A_RXD, 32'h1234); rd(A_RXD, v); chk(v, 32'h0, "R12 rx write ignored");
        // R10 control keeps bit 0 only
        wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); chk(v, 0, "R10 control bit 0 only");

        // R5 disabled channel holds the word
        wr(A_CONF, conf_word(0, 7, 1, 1, 0, 0));
        e0 = sclk_edges;
        wr(A_TXD, 32'hA5);
        repeat (20) @(negedge clk);
        rd(A_STAT, v); chk(v, 32'h0, "R5 R7 disabled no transfer");
        chk(32'(sclk_edges - e0), 0, "R5 no sclk while disabled");
        chk({31'd0, tx_dma_req}, 0, "R8 no tx dma while disabled");

        // R10 enabling starts the pending word
        mark = sclk_edges;
        wr(A_CTRL, 32'h1);
        wait_done();
        rd(A_STAT, v); chk(v, 32'h7, "R4 status after transfer");
        chk(32'(sclk_edges - mark), 8, "R11 edge count");
        chk({31'd0, first_mosi}, 1, "R11 msb first");
        chk({31'd0, evt_rx_full}, 1, "R9 rx full event");
        chk({31'd0, evt_tx_empty}, 1, "R9 tx empty event");
        chk({30'd0, tx_dma_req, rx_dma_req}, 3, "R8 both dma requests");
        rd(A_TXD, v); chk(v, 0, "R4 tx cleared");
        rd(A_RXD, v); chk(v, exp_rx(32'hA5, 8), "R3 rx word");
        rd(A_STAT, v); chk(v, 32'h6, "R7 rx read clears full");

        // R5 receive full blocks the next word
        wr(A_TXD, 32'h3C); wait_done();
        e0 = sclk_edges;
        wr(A_TXD, 32'h0F);
        repeat (40) @(negedge clk);
        rd(A_STAT, v); chk(v, 32'h5, "R5 blocked by rx full");
        chk(32'(sclk_edges - e0), 0, "R5 no sclk while blocked");
        rd(A_RXD, v); chk(v, exp_rx(32'h3C, 8), "R3 first word");
        wait_done();
        rd(A_RXD, v); chk(v, exp_rx(32'h0F, 8), "R7 read releases word");

        // R13 short length field, eot clears at start
        wr(A_CONF, conf_word(0, 1, 0, 0, 0, 0));
        mark = sclk_edges;
        wr(A_TXD, 32'hB);
        repeat (3) @(negedge clk);
        rd(A_STAT, v); chk(v, 32'h0, "R13 eot cleared at start");
        wait_done();
        chk(32'(sclk_edges - mark), 4, "R13 short field shifts 4");
        rd(A_RXD, v); chk(v, exp_rx(32'hB, 4), "R13 rx of 4 bits");

        // R14-like transmit-only behaviour under R4
        wr(A_CONF, conf_word(2, 7, 0, 1, 0, 0));
        wr(A_TXD, 32'h81); wait_done();
        rd(A_STAT, v); chk(v, 32'h6, "R4 tx-only leaves rx full clear");
        chk({31'd0, evt_rx_full}, 0, "R9 no rx event tx-only");
        chk({31'd0, rx_dma_req}, 0, "R8 no rx dma tx-only");

        // R10 receive-only starts on enable
        wr(A_CTRL, 32'h0);
        wr(A_CONF, conf_word(1, 7, 1, 0, 0, 0));
        mark = sclk_edges;
        wr(A_CTRL, 32'h1);
        wait_done();
        chk(32'(sclk_edges - mark), 8, "R10 rx-only starts on enable");
        rd(A_STAT, v); chk(v, 32'h7, "R4 rx-only status");
        chk({31'd0, tx_dma_req}, 0, "R8 no tx dma rx-only");
        chk({31'd0, evt_tx_empty}, 0, "R9 no tx event rx-only");
        rd(A_RXD, v); chk(v, 32'hFF, "R3 rx-only receives");
        wait_done();

        // turbo: rx full does not block
        wr(A_CONF, conf_word(0, 7, 0, 0, 1, 0));
        wr(A_TXD, 32'h11); wait_done();
        chk({31'd0, evt_rx_full}, 0, "R9 turbo hides rx event");
        wr(A_TXD, 32'h22); wait_done();
        rd(A_RXD, v); chk(v, exp_rx(32'h22, 8), "R5 turbo overrun allowed");

        // R6 single-channel gating and force
        single_chan = 1'b1;
        wr(A_CONF, conf_word(0, 7, 0, 0, 0, 0));
        rd(A_RXD, prev);
        e0 = sclk_edges;
        wr(A_TXD, 32'h55);
        repeat (20) @(negedge clk);
        rd(A_STAT, v); chk(v, 32'h7, "R6 quick completion status");
        chk(32'(sclk_edges - e0), 0, "R6 no sclk in single mode");
        rd(A_RXD, v); chk(v, prev, "R6 rx unchanged");
        wr(A_CONF, conf_word(0, 7, 0, 0, 0, 1));
        mark = sclk_edges;
        wr(A_TXD, 32'h55); wait_done();
        chk(32'(sclk_edges - mark), 8, "R6 force shifts");
        rd(A_RXD, v); chk(v, 32'hAA, "R6 forced rx");
        single_chan = 1'b0;

        // random words and lengths
        for (int i = 0; i < 40; i++) begin
            int lenf = 3 + int'($urandom % 29);
            logic [31:0] w = $urandom;
            wr(A_CONF, conf_word(0, lenf, 0, 0, 0, 0));
            mark = sclk_edges;
            wr(A_TXD, w); wait_done();
            chk(32'(sclk_edges - mark), 32'(lenf + 1), "R11 random edge count");
            rd(A_RXD, v); chk(v, exp_rx(w, lenf + 1), "R3 random rx word");
        end

        finish_run();
    end
endmodule